// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A mode register takes a 12-bit mode word whenever a load strobe is present. The block decodes four settings from that word: burst length, burst ordering, CAS latency and write mode. After a start strobe that carries a starting column, the block puts out one column address per clock for the number of beats that the mode selects. A valid flag is high on every beat, and a last flag is high on the final beat of a burst of fixed length.

Sequential ordering counts upward inside the aligned block whose size is the burst length, and wraps inside that block. Interleaved ordering XORs the starting column with the beat index. A full-page burst is allowed only with sequential ordering. It steps through all 1024 columns and keeps wrapping until a terminate strobe arrives. When single-beat write mode is selected, every write burst is one beat long. Reads keep the programmed length. The block also reports the effective read latency, which is one cycle longer when the registered-command option is on. A mode word that has a reserved code sets an error flag, and the previous settings stay in force.

Top module: `sdram_burst_agen`

## Requirements
- R1: Mode bits [2:0] select the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page (sequential ordering only). Each start launches a burst of that many beats.
- R2: When mode bit [3] is 0, ordering is sequential. Beat i goes to column base + ((start mod L) + i) mod L, where base is the start column with its low log2(L) bits cleared.
- R3: When mode bit [3] is 1, ordering is interleaved. Beat i goes to column base + ((start mod L) XOR i).
- R4: A full-page burst steps through columns (start + i) mod 1024 with no last flag. It ends only when a terminate strobe is sampled.
- R5: A mode word with length code 111 and mode bit [3] = 1 is reserved.
- R6: Mode bits [6:4] select the CAS latency: 010 gives 2 and 011 gives 3. rd_latency reports the value that is in force.
- R7: While latch_mode is 1, rd_latency equals the CAS latency plus one.
- R8: When mode bit [9] is 1, a burst started with is_write = 1 is exactly one beat long. Reads keep the programmed length.
- R9: A load whose word has a reserved length code or latency code, or a nonzero bit [11], [8] or [7], sets mode_err to 1 and leaves every setting unchanged. A legal load clears mode_err and applies the new settings. mode_err changes only on a load.
- R10: The first beat is valid in the cycle after the clock edge that samples start. One beat follows per clock. beat_last is high only on the final beat, and beat_valid falls in the cycle after that.
- R11: A terminate strobe sampled during a burst ends it. beat_valid is 0 from the next cycle on.
- R12: After reset no burst is active and mode_err is 0. The settings are length 1, sequential ordering, CAS latency 2 and burst write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load strobe for the mode word |
| mode_word | input | 12 | Mode word |
| latch_mode | input | 1 | Registered-command option; adds one cycle of read latency |
| start | input | 1 | Starts a burst |
| start_col | input | 10 | Starting column |
| is_write | input | 1 | Burst is a write |
| terminate | input | 1 | Ends the current burst |
| col_addr | output | 10 | Column address of the current beat |
| beat_valid | output | 1 | A beat is present |
| beat_last | output | 1 | Final beat of a burst of fixed length |
| rd_latency | output | 3 | Effective read latency in cycles |
| mode_err | output | 1 | The most recent load held a reserved code |

## Verification
A wrong beat counter or a wrong wrap mask shows up as a column mismatch on the first beat that crosses the boundary of its aligned block, so every burst position is compared. A corrupted length register shows up as beat_last on the wrong beat, or as beat_valid staying high one cycle too long. Every burst ends with a check that the valid flag has dropped. A bad mode decode shows up one cycle after the load, either in mode_err and rd_latency or in the length and ordering of the next burst.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    localparam int MODE_W = 12;
    localparam int LOG2_W = 2;
    localparam int CAS_W  = 3;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic [LOG2_W-1:0] len_log2;
        logic              full_page;
        burst_order_e      order;
        logic [CAS_W-1:0]  cas;
        logic              single_wr;
    } mode_cfg_t;

    typedef struct packed {
        mode_cfg_t cfg;
        logic      legal;
    } mode_dec_t;

    localparam mode_cfg_t MODE_RESET = '{
        len_log2:  '0,
        full_page: 1'b0,
        order:     ORD_SEQ,
        cas:       CAS_W'(2),
        single_wr: 1'b0
    };

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] w);
        mode_dec_t d;
        d.cfg.len_log2  = '0;
        d.cfg.full_page = 1'b0;
        d.cfg.order     = burst_order_e'(w[3]);
        d.cfg.cas       = w[6:4];
        d.cfg.single_wr = w[9];
        d.legal         = (w[11] == 1'b0) && (w[8:7] == 2'b00);
        case (w[2:0])
            3'b000: d.cfg.len_log2 = LOG2_W'(0);
            3'b001: d.cfg.len_log2 = LOG2_W'(1);
            3'b010: d.cfg.len_log2 = LOG2_W'(2);
            3'b011: d.cfg.len_log2 = LOG2_W'(3);
            3'b111: begin
                d.cfg.full_page = 1'b1;
                if (w[3]) d.legal = 1'b0;
            end
            default: d.legal = 1'b0;
        endcase
        if (w[6:4] != 3'b010 && w[6:4] != 3'b011) d.legal = 1'b0;
        return d;
    endfunction

    function automatic logic [15:0] len_mask(input mode_cfg_t c);
        logic [15:0] m;
        if (c.full_page) m = '1;
        else             m = (16'd1 << c.len_log2) - 16'd1;
        return m;
    endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output mode_cfg_t         cfg,
    output logic              err
);
    mode_dec_t dec;

    always_comb dec = decode_mode(word);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= MODE_RESET;
            err <= 1'b0;
        end else if (load) begin
            err <= !dec.legal;
            if (dec.legal) cfg <= dec.cfg;
        end
    end
endmodule

// File: rtl/sdram_col_calc.sv
module sdram_col_calc
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] col0,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  burst_order_e     order,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] off;

    always_comb begin
        base = col0 & ~mask;
        if (order == ORD_ILV) off = (col0 ^ beat) & mask;
        else                  off = (col0 + beat) & mask;
        col = base | off;
    end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             is_write,
    input  logic             terminate,
    input  mode_cfg_t        cfg,
    output logic [COL_W-1:0] col0,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] mask,
    output burst_order_e     order,
    output logic             active,
    output logic             last
);
    logic        one_beat;
    logic        open_end;
    logic [15:0] cfg_mask;

    always_comb begin
        one_beat = is_write && cfg.single_wr;
        cfg_mask = len_mask(cfg);
        last     = active && !open_end && (beat == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            open_end <= 1'b0;
            beat     <= '0;
            col0     <= '0;
            mask     <= '0;
            order    <= ORD_SEQ;
        end else if (start) begin
            active   <= 1'b1;
            beat     <= '0;
            col0     <= start_col;
            order    <= cfg.order;
            open_end <= cfg.full_page && !one_beat;
            mask     <= one_beat ? '0 : cfg_mask[COL_W-1:0];
        end else if (active) begin
            if (terminate || last) active <= 1'b0;
            else                   beat   <= beat + 1'b1;
        end
    end
endmodule

// File: rtl/sdram_burst_agen.sv
module sdram_burst_agen
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              latch_mode,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              is_write,
    input  logic              terminate,
    output logic [COL_W-1:0]  col_addr,
    output logic              beat_valid,
    output logic              beat_last,
    output logic [CAS_W-1:0]  rd_latency,
    output logic              mode_err
);
    mode_cfg_t        cfg;
    logic [COL_W-1:0] col0;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] mask;
    burst_order_e     order;

    sdram_mode_reg u_mode (
        .clk  (clk),
        .rst  (rst),
        .load (mode_load),
        .word (mode_word),
        .cfg  (cfg),
        .err  (mode_err)
    );

    sdram_burst_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_col (start_col),
        .is_write  (is_write),
        .terminate (terminate),
        .cfg       (cfg),
        .col0      (col0),
        .beat      (beat),
        .mask      (mask),
        .order     (order),
        .active    (beat_valid),
        .last      (beat_last)
    );

    sdram_col_calc #(.COL_W(COL_W)) u_calc (
        .col0  (col0),
        .beat  (beat),
        .mask  (mask),
        .order (order),
        .col   (col_addr)
    );

    always_comb rd_latency = cfg.cas + CAS_W'(latch_mode);
endmodule

// File: rtl/sdram_burst_agen_chk.sv
module sdram_burst_agen_chk
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_load,
    input logic              latch_mode,
    input logic              start,
    input logic              terminate,
    input logic              beat_valid,
    input logic              beat_last,
    input logic [CAS_W-1:0]  rd_latency,
    input logic              mode_err
);
    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid); // R10
    AST_START_GIVES_BEAT: assert property (@(posedge clk) disable iff (rst)
        start |=> beat_valid); // R10
    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
        (beat_last && !start) |=> !beat_valid); // R10
    AST_TERM_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
        (terminate && !start) |=> !beat_valid); // R11
    AST_LAT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (rd_latency >= CAS_W'(2)) && (rd_latency <= CAS_W'(4))); // R6
    AST_LATCH_ADDS_ONE: assert property (@(posedge clk) disable iff (rst)
        (!$past(mode_load) && latch_mode && !$past(latch_mode))
            |-> rd_latency == $past(rd_latency) + CAS_W'(1)); // R7
    AST_ERR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$past(mode_load) |-> mode_err == $past(mode_err)); // R9
endmodule

bind sdram_burst_agen sdram_burst_agen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_burst_agen_bench.sv
module sdram_burst_agen_bench;
    localparam int COL_W = 10;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_load = 1'b0;
    logic [11:0]      mode_word = '0;
    logic             latch_mode = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             is_write = 1'b0;
    logic             terminate = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             beat_valid;
    logic             beat_last;
    logic [2:0]       rd_latency;
    logic             mode_err;

    int checks = 0;
    int errors = 0;
    int m_len = 1;   // 0 = full page
    int m_ilv = 0;
    int m_cl  = 2;
    int m_sw  = 0;
    int m_err = 0;

    always #2 clk = ~clk;

    sdram_burst_agen #(.COL_W(COL_W)) u_sdram_burst_agen (.*);

    function automatic int word_len(input logic [11:0] w);
        if (w[2:0] == 3'b111) return 0;
        return 1 << w[1:0];
    endfunction

    function automatic bit word_ok(input logic [11:0] w);
        bit ok = 1;
        if (w[11] || w[8] || w[7]) ok = 0;
        if (!(w[2:0] <= 3'd3 || (w[2:0] == 3'b111 && !w[3]))) ok = 0;
        if (!(w[6:4] == 3'd2 || w[6:4] == 3'd3)) ok = 0;
        return ok;
    endfunction

    function automatic int exp_col(input int s, input int i, input int len, input int ilv);
        int base;
        if (len == 0) return (s + i) % PAGE;
        base = s - (s % len);
        if (ilv != 0) return base + ((s % len) ^ i);
        return base + ((s % len) + i) % len;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [11:0] w, input logic lm);
        bit ok;
        ok = word_ok(w);
        @(negedge clk);
        mode_load = 1'b1; mode_word = w; latch_mode = lm;
        @(negedge clk);
        mode_load = 1'b0;
        if (ok) begin
            m_len = word_len(w); m_ilv = w[3]; m_cl = w[6:4]; m_sw = w[9];
        end
        m_err = ok ? 0 : 1;
        check(mode_err == m_err, "R9", "mode_err", mode_err, m_err);
        check(rd_latency == m_cl + lm, lm ? "R7" : "R6", "rd_latency",
              rd_latency, m_cl + lm);
    endtask

    // nrun: beats to watch before terminate when term is set
    task automatic burst(input int col, input bit wr, input int nrun, input bit term);
        int len, n, ec;
        bit el;
        len = (wr && m_sw != 0) ? 1 : m_len;
        n = (len == 0 || (term && nrun < len)) ? nrun : len;
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(col); is_write = wr;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            ec = exp_col(col, i, len, m_ilv);
            el = (len != 0) && (i == len - 1);
            check(beat_valid && col_addr == COL_W'(ec),
                  len == 0 ? "R4" : (m_ilv != 0 ? "R3" : "R2"),
                  "col_addr", beat_valid ? col_addr : -1, ec);
            check(beat_last == el, "R10", "beat_last", beat_last, el);
            if (i == n - 1 && term) terminate = 1'b1;
        end
        @(negedge clk);
        terminate = 1'b0;
        check(!beat_valid, term ? "R11" : (wr && m_sw != 0 ? "R8" : "R1"),
              "valid after end", beat_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(!beat_valid && !beat_last, "R12", "idle after reset", beat_valid, 0);
        check(mode_err == 1'b0, "R12", "mode_err after reset", mode_err, 0);
        check(rd_latency == 3'd2, "R12", "latency after reset", rd_latency, 2);
        burst(37, 1'b0, 0, 1'b0);                 // R12 length 1
        // R1 R2 sequential length 8 wrapping
        load(12'b0000_0010_0011, 1'b0);
        burst(13, 1'b0, 0, 1'b0);
        // R3 interleaved length 4
        load(12'b0000_0011_1010, 1'b1);
        burst(6, 1'b1, 0, 1'b0);
        // R5 interleaved full page reserved; settings kept
        load(12'b0000_0010_1111, 1'b0);
        burst(6, 1'b0, 0, 1'b0);
        // R9 reserved bit 8, latency code 4
        load(12'b0001_0010_0001, 1'b0);
        load(12'b0000_0100_0001, 1'b0);
        // R4 full page wrap at top of page
        load(12'b0000_0011_0111, 1'b1);
        burst(1020, 1'b0, 9, 1'b1);
        // R8 single write vs read
        load(12'b0010_0010_0011, 1'b0);
        burst(21, 1'b1, 0, 1'b0);
        burst(21, 1'b0, 0, 1'b0);
        // R11 terminate a fixed burst early
        burst(3, 1'b0, 3, 1'b1);
        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [11:0] w;
            logic [2:0]  blc;
            int r = $urandom_range(0, 5);
            blc = (r == 5) ? 3'b111 : 3'($urandom_range(0, 3));
            w = {2'b00, 1'($urandom_range(0, 1)), 2'b00,
                 3'($urandom_range(2, 3)), 1'($urandom_range(0, 1)), blc};
            if ($urandom_range(0, 5) == 0) w = 12'($urandom);
            load(w, 1'($urandom_range(0, 1)));
            burst($urandom_range(0, PAGE - 1), 1'($urandom_range(0, 1)),
                  $urandom_range(1, 20), ($urandom_range(0, 3) == 0) || (m_len == 0));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule